// File: doc/BRIEF.md
# Two-Stage Soft Reset Sequencer

This block sequences software-initiated resets for a network MAC core and for the control module beside it, which holds the transfer-descriptor memory. Software sets a request bit through a small register port. The MAC core reset is not applied at once. The sequencer first waits until both the receive and transmit DMA engines report idle, so that no configuration-bus transaction is cut short. It then drives a fixed-length reset pulse. Until that pulse has finished, the request bit reads back as 1, and software polls it for 0.

The control-module reset must come after the MAC reset. If software requests it while a MAC reset is still outstanding, the request is held back until the MAC reset completes, and a sequence-error flag is raised. When the control-module reset runs, it pulses the control logic reset. It then walks the whole descriptor memory, one zero-write per cycle, and its request bit reads 1 until the last word has been cleared.

Either reset returns the MAC configuration register to its default value. This register is modelled here as one read/write word.

Top module: `soft_rst_seq`

## Requirements
- R1: After rst_n is released, register 0 and register 1 read 0, register 2 reads CFG_DEFAULT, register 3 reads 0, and mac_rst_o, ctl_rst_o and clr_we_o are low.
- R2: A write with bit 0 set to register 0 requests a MAC reset. mac_rst_o stays low for as long as either rx_dma_idle_i or tx_dma_idle_i is low.
- R3: Register 0 bit 0 reads 1 from the cycle after the request write until the MAC pulse ends, and reads 0 from the cycle after that.
- R4: mac_rst_o rises on the first clock edge at which both idle inputs are seen high during a pending request. It stays high for exactly PULSE_CYC (4) cycles.
- R5: While mac_rst_o or ctl_rst_o is high, register 2 returns to CFG_DEFAULT and writes to it are lost.
- R6: A write with bit 0 set to register 1 requests a control-module reset. ctl_rst_o never rises while a MAC reset is pending, and the held request starts on its own once the MAC reset is complete.
- R7: A control-module request made while a MAC reset is pending sets register 1 bit 1 (sequence error). The bit is cleared by the control-module pulse.
- R8: After the ctl_rst_o pulse of PULSE_CYC cycles, clr_we_o is high for CLR_WORDS (2048) consecutive cycles, with clr_addr_o stepping 0, 1, … CLR_WORDS-1. Register 1 bit 0 reads 1 until the last word has been written.
- R9: Writing 0 to either reset bit has no effect. Writing 1 while that reset is pending is ignored and produces no second pulse or sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register index (0 MAC reset, 1 control reset, 2 MAC config) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| rx_dma_idle_i | input | 1 | Receive DMA engine idle |
| tx_dma_idle_i | input | 1 | Transmit DMA engine idle |
| mac_rst_o | output | 1 | MAC core reset pulse |
| ctl_rst_o | output | 1 | Control-module reset pulse |
| clr_we_o | output | 1 | Descriptor memory clear write enable (data is zero) |
| clr_addr_o | output | CLR_AW | Descriptor memory clear word address |

## Verification
The bench keeps the request pending while only one DMA engine is idle, then the other. A design that checks a single idle input, or ORs them, would pulse too early. It counts the pulse cycles and times the readback to the exact cycle, which exposes an off-by-one pulse length or a bit that clears before the reset has taken effect. It requests the control-module reset during a pending MAC reset. A design without the ordering rule would pulse the control module first or never raise the error flag. Repeat writes and zero writes during a pending reset are also issued: a design that accepts them would produce a second pulse or extra clear writes, and the address scoreboard reports those.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_WAIT  = 2'd1,
    M_PULSE = 2'd2
  } mac_st_e;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_HOLD  = 2'd1,
    C_PULSE = 2'd2,
    C_CLEAR = 2'd3
  } ctl_st_e;

  localparam int REG_MAC_RST = 0;
  localparam int REG_CTL_RST = 1;
  localparam int REG_MAC_CFG = 2;

endpackage

// File: rtl/srs_mac_seq.sv
module srs_mac_seq
  import srs_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic rx_idle_i,
  input  logic tx_idle_i,
  output logic rst_pulse_o,
  output logic pending_o
);

  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  mac_st_e        st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      M_IDLE: if (req_i) st_d = M_WAIT;
      M_WAIT: if (rx_idle_i && tx_idle_i) begin
        st_d   = M_PULSE;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      M_PULSE: begin
        if (cnt_q == LAST) begin
          st_d = M_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign rst_pulse_o = (st_q == M_PULSE);
  assign pending_o   = (st_q != M_IDLE);

  // R2: the pulse only starts after both engines were seen idle
  assert_idle_before_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |-> $past(rx_idle_i && tx_idle_i));

  // R4: a started pulse lasts more than one cycle
  assert_pulse_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |=> rst_pulse_o);

  // R3: pending drops only as the pulse ends
  assert_pend_until_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_o) |-> $past(rst_pulse_o));

endmodule

// File: rtl/srs_ctl_seq.sv
module srs_ctl_seq
  import srs_pkg::*;
#(
  parameter int PULSE_CYC = 4,
  parameter int CLR_WORDS = 2048,
  localparam int CW     = $clog2(PULSE_CYC + 1),
  localparam int CLR_AW = $clog2(CLR_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              mac_pend_i,
  output logic              rst_pulse_o,
  output logic              pending_o,
  output logic              seq_err_o,
  output logic              clr_we_o,
  output logic [CLR_AW-1:0] clr_addr_o
);

  localparam logic [CW-1:0]     LAST     = CW'(PULSE_CYC - 1);
  localparam logic [CLR_AW-1:0] LAST_ADR = CLR_AW'(CLR_WORDS - 1);

  ctl_st_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic [CLR_AW-1:0] adr_q, adr_d;
  logic              adr_en;
  logic              err_q, err_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    adr_d  = adr_q;
    adr_en = 1'b0;
    err_d  = err_q;
    unique case (st_q)
      C_IDLE: if (req_i) begin
        cnt_d  = '0;
        cnt_en = 1'b1;
        if (mac_pend_i) begin
          st_d  = C_HOLD;
          err_d = 1'b1;
        end else begin
          st_d = C_PULSE;
        end
      end
      C_HOLD: if (!mac_pend_i) begin
        st_d   = C_PULSE;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      C_PULSE: begin
        err_d = 1'b0;
        if (cnt_q == LAST) begin
          st_d   = C_CLEAR;
          adr_d  = '0;
          adr_en = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      C_CLEAR: begin
        if (adr_q == LAST_ADR) begin
          st_d = C_IDLE;
        end else begin
          adr_d  = adr_q + 1'b1;
          adr_en = 1'b1;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      cnt_q <= '0;
      adr_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (adr_en) adr_q <= adr_d;
    end
  end

  assign rst_pulse_o = (st_q == C_PULSE);
  assign pending_o   = (st_q != C_IDLE);
  assign seq_err_o   = err_q;
  assign clr_we_o    = (st_q == C_CLEAR);
  assign clr_addr_o  = adr_q;

  // R6: the control pulse never starts while the MAC reset is outstanding
  assert_order_mac_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |-> !$past(mac_pend_i));

  // R7: the error flag rises only on an early request
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err_o) |-> $past(mac_pend_i && req_i));

  // R8: clear addresses advance by one on consecutive cycles
  assert_clear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_o && clr_addr_o != '0) |-> ($past(clr_we_o) && $past(clr_addr_o) == clr_addr_o - CLR_AW'(1)));

  // R8: the sweep starts right after the pulse
  assert_clear_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse_o) |-> (clr_we_o && clr_addr_o == '0));

endmodule

// File: rtl/soft_rst_seq.sv
module soft_rst_seq
  import srs_pkg::*;
#(
  parameter int              ADDR_W      = 2,
  parameter int              DATA_W      = 32,
  parameter int              PULSE_CYC   = 4,
  parameter int              CLR_WORDS   = 2048,
  parameter logic [31:0]     CFG_DEFAULT = 32'h0000_0100,
  localparam int             CLR_AW      = $clog2(CLR_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rx_dma_idle_i,
  input  logic              tx_dma_idle_i,
  output logic              mac_rst_o,
  output logic              ctl_rst_o,
  output logic              clr_we_o,
  output logic [CLR_AW-1:0] clr_addr_o
);

  localparam logic [DATA_W-1:0] CFG_DEF = DATA_W'(CFG_DEFAULT);

  logic              sel_mac, sel_ctl, sel_cfg;
  logic              mac_req, ctl_req, cfg_we;
  logic              mac_pend, ctl_pend, seq_err;
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;

  assign sel_mac = (reg_addr_i == ADDR_W'(REG_MAC_RST));
  assign sel_ctl = (reg_addr_i == ADDR_W'(REG_CTL_RST));
  assign sel_cfg = (reg_addr_i == ADDR_W'(REG_MAC_CFG));

  assign mac_req = reg_wr_i && sel_mac && reg_wdata_i[0];
  assign ctl_req = reg_wr_i && sel_ctl && reg_wdata_i[0];
  assign cfg_we  = reg_wr_i && sel_cfg;

  srs_mac_seq #(.PULSE_CYC(PULSE_CYC)) u_mac (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (mac_req),
    .rx_idle_i   (rx_dma_idle_i),
    .tx_idle_i   (tx_dma_idle_i),
    .rst_pulse_o (mac_rst_o),
    .pending_o   (mac_pend)
  );

  srs_ctl_seq #(.PULSE_CYC(PULSE_CYC), .CLR_WORDS(CLR_WORDS)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (ctl_req),
    .mac_pend_i  (mac_pend),
    .rst_pulse_o (ctl_rst_o),
    .pending_o   (ctl_pend),
    .seq_err_o   (seq_err),
    .clr_we_o    (clr_we_o),
    .clr_addr_o  (clr_addr_o)
  );

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (mac_rst_o || ctl_rst_o) begin
      cfg_d  = CFG_DEF;
      cfg_en = 1'b1;
    end else if (cfg_we) begin
      cfg_d  = reg_wdata_i;
      cfg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEF;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_mac)      reg_rdata_o[0]   = mac_pend;
    else if (sel_ctl) reg_rdata_o[1:0] = {seq_err, ctl_pend};
    else if (sel_cfg) reg_rdata_o      = cfg_q;
  end

  // R5: any reset pulse leaves the configuration at its default
  assert_cfg_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_rst_o || ctl_rst_o) |=> (cfg_q == CFG_DEF));

endmodule

// File: tb/soft_rst_seq_tb.sv
module soft_rst_seq_tb_top;

  localparam int          CLR_WORDS = 2048;
  localparam int          CLR_AW    = $clog2(CLR_WORDS);
  localparam logic [31:0] CFG_DEF   = 32'h0000_0100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              rx_idle = 1'b1;
  logic              tx_idle = 1'b1;
  logic              mac_rst, ctl_rst, clr_we;
  logic [CLR_AW-1:0] clr_addr;

  int n_chk = 0;
  int n_fail = 0;
  int mac_pulses = 0;
  int ctl_pulses = 0;
  int cyc = 0;
  int last_mac_cyc = -1;
  int ctl_start_cyc = -1;
  logic ctl_prev = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  soft_rst_seq #(.CLR_WORDS(CLR_WORDS), .CFG_DEFAULT(CFG_DEF)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_i      (reg_wr),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .rx_dma_idle_i (rx_idle),
    .tx_dma_idle_i (tx_idle),
    .mac_rst_o     (mac_rst),
    .ctl_rst_o     (ctl_rst),
    .clr_we_o      (clr_we),
    .clr_addr_o    (clr_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pulse counters and clear-address scoreboard
  always @(negedge clk) begin
    cyc++;
    if (mac_rst) begin
      mac_pulses++;
      last_mac_cyc = cyc;
    end
    if (ctl_rst) ctl_pulses++;
    if (ctl_rst && !ctl_prev) ctl_start_cyc = cyc;
    ctl_prev = ctl_rst;
    if (clr_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8/R9: got clear write at %0d expected none", clr_addr);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(clr_addr) != e) begin
          n_fail++;
          $display("FAIL R8: got clear addr %0d expected %0d", clr_addr, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push_sweep();
    for (int i = 0; i < CLR_WORDS; i++) exp_q.push_back(i);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int mac_base, ctl_base;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    rd(2'd0, d); chk("R1 mac bit", d, 32'h0);
    rd(2'd1, d); chk("R1 ctl reg", d, 32'h0);
    rd(2'd2, d); chk("R1 cfg", d, CFG_DEF);
    rd(2'd3, d); chk("R1 unused", d, 32'h0);
    chk("R1 outputs", {29'h0, mac_rst, ctl_rst, clr_we}, 32'h0);

    // R2/R3/R4/R5/R9: MAC reset held off by busy engines
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, d); chk("R5 cfg write", d, 32'h1234_5678);
    rx_idle = 1'b0;
    wr(2'd0, 32'h1);
    step(6);
    chk("R2 no pulse rx busy", mac_pulses, 0);
    rd(2'd0, d); chk("R3 pending", d, 32'h1);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R9 zero write", d, 32'h1);
    wr(2'd0, 32'h1);
    rx_idle = 1'b1;
    tx_idle = 1'b0;
    step(5);
    chk("R2 no pulse tx busy", mac_pulses, 0);
    tx_idle = 1'b1;
    step(1);
    chk("R4 pulse starts", mac_pulses, 1);
    step(3);
    rd(2'd0, d); chk("R3 still pending in pulse", d, 32'h1);
    chk("R4 pulse count", mac_pulses, 4);
    step(1);
    rd(2'd0, d); chk("R3 reads 0 after", d, 32'h0);
    chk("R4 pulse ended", {31'h0, mac_rst}, 32'h0);
    rd(2'd2, d); chk("R5 cfg restored by MAC", d, CFG_DEF);
    step(10);
    chk("R9 no second MAC pulse", mac_pulses, 4);

    // R8/R5/R9: control-module reset with MAC idle
    wr(2'd2, 32'h0000_dead);
    push_sweep();
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R8 ctl pending", d, 32'h1);
    step(10);
    wr(2'd1, 32'h1);
    step(2039);
    rd(2'd1, d); chk("R8 pending on last word", d, 32'h1);
    step(1);
    rd(2'd1, d); chk("R8 done", d, 32'h0);
    chk("R8 sweep complete", exp_q.size(), 0);
    chk("R9 single ctl pulse", ctl_pulses, 4);
    rd(2'd2, d); chk("R5 cfg restored by ctl", d, CFG_DEF);

    // R6/R7: control request during pending MAC reset
    mac_base = mac_pulses;
    ctl_base = ctl_pulses;
    rx_idle = 1'b0;
    wr(2'd0, 32'h1);
    push_sweep();
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R7 seq error set", d, 32'h3);
    step(8);
    chk("R6 ctl held", ctl_pulses, ctl_base);
    chk("R6 no clear yet", exp_q.size(), CLR_WORDS);
    rx_idle = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, d);
      if (d == 32'h0) break;
      step(1);
    end
    rd(2'd1, d); chk("R7 error cleared, done", d, 32'h0);
    chk("R6 MAC pulsed", mac_pulses - mac_base, 4);
    chk("R6 ctl after MAC", {31'h0, ctl_start_cyc > last_mac_cyc}, 32'h1);
    chk("R8 second sweep complete", exp_q.size(), 0);
    rd(2'd0, d); chk("R3 MAC idle", d, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule